// File: doc/BRIEF.md
# Power Manager Wake-Up Detector

This block gathers the external events that may pull a power-management sequencer out of a low-power state. It watches six DMA request lines, four interrupt lines (a keyboard line plus three acknowledge-capable channels), an active-low ring-indicate input and an AC-present input. Each source is synchronised, edge-detected with its own polarity, and latched into a sticky status bit. Each bit is released by that source's own rule: the line returning to idle, an acknowledge followed by an end-of-interrupt, or a memory refresh strobe.

A per-source enable mask decides which status bits are counted. When the OR of enabled, set status bits goes from 0 to 1, the block emits one pulse. In a sleeping mode the pulse is a wake request. In a slowed mode it is an activity pulse. The same rising edge clears the inactivity timer. The block also drives the inactivity timer's hold: the hold is set after a system-management event until software acknowledges it, and during a PLL start-up until the PLL reports ready. All pins are plain control and status signals. No stream interface exists, so there is no back-pressure.

Top module: `wk_detect`

## Requirements
- R1: A rising edge on `dma_req_i[i]` sets status bit i (bits 0..5). The bit becomes visible 3 clock edges after the input changes. It clears when the line is low again, with the same latency.
- R2: A rising edge on `irq_i[j]` sets status bit 6+j. Bit 6 (keyboard) clears only when its line goes low. Bits 7..9 also clear on `eoi_i[j-1]` once `inta_i[j-1]` has been seen while the bit was set. An EOI without a prior acknowledge has no effect.
- R3: A falling edge on `ring_n_i` sets status bit 10. Only a `refresh_i` strobe clears it. Writing 1 to bit 10 and the line going high both have no effect.
- R4: Status bit 11 (rising edge of `ac_present_i`) counts as enabled only when mask bit 11 and control bit 0 (address 2) are both 1.
- R5: Writing 1 to a status bit at address 1 clears bits 0..9 and 11. Writing 0 leaves a bit unchanged. Address 0 is the enable mask (read/write, bits 11:0), and it reads back what was written.
- R6: When the OR of enabled status bits rises, `wake_o` pulses for one cycle if `mode_i` is 3, 4 or 5 (sleep, suspend, off). `activity_o` pulses for one cycle if the mode is 1 or 2 (low-speed, doze). Neither pulses in mode 0 (high-speed) or in codes 6 and 7.
- R7: A source whose enable bit is 0 still records its status bit but produces no pulse.
- R8: `timer_clr_o` pulses for one cycle, one cycle after the enabled OR rises in any mode, and one cycle after any write to address 3.
- R9: `timer_hold_o` is high from the cycle after `smi_event_i` until the cycle after a write to address 4.
- R10: `timer_hold_o` is high from the cycle after `pll_start_i` until the cycle after `pll_ready_i`.
- R11: After reset the mask, control and status read 0, and all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req_i | input | 6 | Raw DMA request lines (status bits 0..5) |
| irq_i | input | 4 | Raw interrupt lines: keyboard, then three acknowledge-capable channels |
| ring_n_i | input | 1 | Raw ring-indicate, active low |
| ac_present_i | input | 1 | Raw AC-present input |
| inta_i | input | 3 | Interrupt-acknowledge strobes for irq_i[3:1] |
| eoi_i | input | 3 | End-of-interrupt strobes for irq_i[3:1] |
| refresh_i | input | 1 | Memory refresh strobe |
| mode_i | input | 3 | Current power mode code |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from address) |
| smi_event_i | input | 1 | System-management event that holds the timer |
| pll_start_i | input | 1 | PLL start-up begins |
| pll_ready_i | input | 1 | PLL start-up complete |
| wake_o | output | 1 | One-cycle wake request |
| activity_o | output | 1 | One-cycle activity pulse |
| timer_clr_o | output | 1 | One-cycle inactivity-timer clear |
| timer_hold_o | output | 1 | Inactivity-timer hold level |

## Verification
The assertions assume that `mode_i` holds steady around a pulse. They also assume that `smi_event_i` and `pll_start_i` are not raised in the same cycle as their own release. The stimulus changes the mode only while every line is idle and all status is clear. It issues each hold request and its release in separate cycles. It drives the acknowledge and EOI strobes only as single-cycle pulses on a channel whose status is set.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int N_DMA    = 6;
  localparam int N_IRQ    = 4;
  localparam int N_ACK    = N_IRQ - 1;
  localparam int IDX_RING = N_DMA + N_IRQ;
  localparam int IDX_AC   = IDX_RING + 1;
  localparam int N_SRC    = IDX_AC + 1;

  localparam int A_MASK    = 0;
  localparam int A_STATUS  = 1;
  localparam int A_CTRL    = 2;
  localparam int A_MODECMD = 3;
  localparam int A_SMIACK  = 4;

  typedef enum logic [2:0] {
    MODE_HIGH  = 3'd0,
    MODE_LOW   = 3'd1,
    MODE_DOZE  = 3'd2,
    MODE_SLEEP = 3'd3,
    MODE_SUSP  = 3'd4,
    MODE_OFF   = 3'd5
  } mode_e;

  function automatic logic mode_is_asleep(logic [2:0] m);
    return (m == MODE_SLEEP) || (m == MODE_SUSP) || (m == MODE_OFF);
  endfunction

  function automatic logic mode_is_slowed(logic [2:0] m);
    return (m == MODE_LOW) || (m == MODE_DOZE);
  endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST;
      stab_q <= RST;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/wk_src.sv
module wk_src #(
  parameter bit RISE    = 1'b1,
  parameter bit LVL_REL = 1'b1,
  parameter bit ACK_REL = 1'b0,
  parameter bit REF_REL = 1'b0,
  parameter bit SW_CLR  = 1'b1,
  parameter bit IDLE    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic w1c_i,
  input  logic inta_i,
  input  logic eoi_i,
  input  logic refresh_i,
  output logic status_o
);
  logic lvl;
  logic prev_q;
  logic st_q;
  logic acked_q;
  logic edge_hit;
  logic idle_now;
  logic release_now;

  wk_sync #(.W(1), .RST(IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;
  end

  assign edge_hit    = RISE ? (lvl & ~prev_q) : (~lvl & prev_q);
  assign idle_now    = (lvl == IDLE);
  assign release_now = (LVL_REL && idle_now)
                    || (ACK_REL && acked_q && eoi_i)
                    || (REF_REL && refresh_i)
                    || (SW_CLR && w1c_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           st_q <= 1'b0;
    else if (edge_hit)    st_q <= 1'b1;
    else if (release_now) st_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              acked_q <= 1'b0;
    else if (edge_hit || release_now)        acked_q <= 1'b0;
    else if (ACK_REL && st_q && inta_i)      acked_q <= 1'b1;
  end

  assign status_o = st_q;
endmodule

// File: rtl/wk_regs.sv
module wk_regs
  import wk_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_SRC-1:0] status_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             ac_en_o,
  output logic [N_SRC-1:0] w1c_o,
  output logic             modecmd_o,
  output logic             smiack_o
);
  localparam logic [AW-1:0] AD_MASK    = AW'(A_MASK);
  localparam logic [AW-1:0] AD_STATUS  = AW'(A_STATUS);
  localparam logic [AW-1:0] AD_CTRL    = AW'(A_CTRL);
  localparam logic [AW-1:0] AD_MODECMD = AW'(A_MODECMD);
  localparam logic [AW-1:0] AD_SMIACK  = AW'(A_SMIACK);

  logic [N_SRC-1:0] mask_q;
  logic             ac_en_q;
  wire              unused_wdata = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      ac_en_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == AD_MASK) mask_q  <= wdata_i[N_SRC-1:0];
      if (addr_i == AD_CTRL) ac_en_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AD_MASK:   rdata_o[N_SRC-1:0] = mask_q;
      AD_STATUS: rdata_o[N_SRC-1:0] = status_i;
      AD_CTRL:   rdata_o[0]         = ac_en_q;
      default:   rdata_o            = '0;
    endcase
  end

  assign w1c_o     = (wr_i && addr_i == AD_STATUS) ? wdata_i[N_SRC-1:0] : '0;
  assign modecmd_o = wr_i && (addr_i == AD_MODECMD);
  assign smiack_o  = wr_i && (addr_i == AD_SMIACK);
  assign mask_o    = mask_q;
  assign ac_en_o   = ac_en_q;
endmodule

// File: rtl/wk_tmr.sv
module wk_tmr (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic modecmd_i,
  input  logic smi_evt_i,
  input  logic smiack_i,
  input  logic pll_start_i,
  input  logic pll_ready_i,
  output logic clr_o,
  output logic hold_o
);
  logic clr_q;
  logic smi_hold_q;
  logic pll_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q      <= 1'b0;
      smi_hold_q <= 1'b0;
      pll_hold_q <= 1'b0;
    end else begin
      clr_q <= rise_i | modecmd_i;
      if (smi_evt_i)        smi_hold_q <= 1'b1;
      else if (smiack_i)    smi_hold_q <= 1'b0;
      if (pll_start_i)      pll_hold_q <= 1'b1;
      else if (pll_ready_i) pll_hold_q <= 1'b0;
    end
  end

  assign clr_o  = clr_q;
  assign hold_o = smi_hold_q | pll_hold_q;
endmodule

// File: rtl/wk_detect.sv
module wk_detect
  import wk_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DMA-1:0] dma_req_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             ring_n_i,
  input  logic             ac_present_i,
  input  logic [N_ACK-1:0] inta_i,
  input  logic [N_ACK-1:0] eoi_i,
  input  logic             refresh_i,
  input  logic [2:0]       mode_i,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             smi_event_i,
  input  logic             pll_start_i,
  input  logic             pll_ready_i,
  output logic             wake_o,
  output logic             activity_o,
  output logic             timer_clr_o,
  output logic             timer_hold_o
);
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] w1c;
  logic [N_SRC-1:0] mask;
  logic [N_SRC-1:0] en_eff;
  logic             ac_en;
  logic             modecmd;
  logic             smiack;
  logic             pend;
  logic             pend_q;
  logic             rise;

  for (genvar i = 0; i < N_DMA; i++) begin : g_dma
    wk_src #(.RISE(1'b1), .LVL_REL(1'b1), .ACK_REL(1'b0),
             .REF_REL(1'b0), .SW_CLR(1'b1), .IDLE(1'b0)) u_src (
      .clk(clk), .rst_n(rst_n), .raw_i(dma_req_i[i]), .w1c_i(w1c[i]),
      .inta_i(1'b0), .eoi_i(1'b0), .refresh_i(1'b0), .status_o(status_q[i])
    );
  end

  for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
    if (j == 0) begin : g_kbd
      wk_src #(.RISE(1'b1), .LVL_REL(1'b1), .ACK_REL(1'b0),
               .REF_REL(1'b0), .SW_CLR(1'b1), .IDLE(1'b0)) u_src (
        .clk(clk), .rst_n(rst_n), .raw_i(irq_i[j]), .w1c_i(w1c[N_DMA+j]),
        .inta_i(1'b0), .eoi_i(1'b0), .refresh_i(1'b0),
        .status_o(status_q[N_DMA+j])
      );
    end else begin : g_ack
      wk_src #(.RISE(1'b1), .LVL_REL(1'b1), .ACK_REL(1'b1),
               .REF_REL(1'b0), .SW_CLR(1'b1), .IDLE(1'b0)) u_src (
        .clk(clk), .rst_n(rst_n), .raw_i(irq_i[j]), .w1c_i(w1c[N_DMA+j]),
        .inta_i(inta_i[j-1]), .eoi_i(eoi_i[j-1]), .refresh_i(1'b0),
        .status_o(status_q[N_DMA+j])
      );
    end
  end

  wk_src #(.RISE(1'b0), .LVL_REL(1'b0), .ACK_REL(1'b0),
           .REF_REL(1'b1), .SW_CLR(1'b0), .IDLE(1'b1)) u_ring (
    .clk(clk), .rst_n(rst_n), .raw_i(ring_n_i), .w1c_i(w1c[IDX_RING]),
    .inta_i(1'b0), .eoi_i(1'b0), .refresh_i(refresh_i),
    .status_o(status_q[IDX_RING])
  );

  wk_src #(.RISE(1'b1), .LVL_REL(1'b1), .ACK_REL(1'b0),
           .REF_REL(1'b0), .SW_CLR(1'b1), .IDLE(1'b0)) u_ac (
    .clk(clk), .rst_n(rst_n), .raw_i(ac_present_i), .w1c_i(w1c[IDX_AC]),
    .inta_i(1'b0), .eoi_i(1'b0), .refresh_i(1'b0),
    .status_o(status_q[IDX_AC])
  );

  wk_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .status_i(status_q),
    .mask_o(mask), .ac_en_o(ac_en), .w1c_o(w1c),
    .modecmd_o(modecmd), .smiack_o(smiack)
  );

  always_comb begin
    en_eff         = mask;
    en_eff[IDX_AC] = mask[IDX_AC] & ac_en;
  end

  assign pend = |(status_q & en_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend;
  end

  assign rise       = pend & ~pend_q;
  assign wake_o     = rise & mode_is_asleep(mode_i);
  assign activity_o = rise & mode_is_slowed(mode_i);

  wk_tmr u_tmr (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .modecmd_i(modecmd),
    .smi_evt_i(smi_event_i), .smiack_i(smiack),
    .pll_start_i(pll_start_i), .pll_ready_i(pll_ready_i),
    .clr_o(timer_clr_o), .hold_o(timer_hold_o)
  );
endmodule

// File: rtl/wk_detect_chk.sv
module wk_detect_chk
  import wk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_i,
  input logic             refresh_i,
  input logic             smi_event_i,
  input logic             pll_start_i,
  input logic             wake_o,
  input logic             activity_o,
  input logic             timer_clr_o,
  input logic             timer_hold_o,
  input logic [N_SRC-1:0] st,
  input logic [N_SRC-1:0] en
);
  assert_wake_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (mode_i == 3'd3 || mode_i == 3'd4 || mode_i == 3'd5));

  assert_act_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    activity_o |-> (mode_i == 3'd1 || mode_i == 3'd2));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o || activity_o) |=> !(wake_o || activity_o));

  assert_pulse_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o || activity_o) |-> (|(st & en)));

  assert_clr_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o || activity_o) |=> timer_clr_o);

  assert_ring_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st[IDX_RING] && !refresh_i) |=> st[IDX_RING]);

  assert_smi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_event_i |=> timer_hold_o);

  assert_pll_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pll_start_i |=> timer_hold_o);
endmodule

bind wk_detect wk_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .refresh_i(refresh_i),
  .smi_event_i(smi_event_i), .pll_start_i(pll_start_i),
  .wake_o(wake_o), .activity_o(activity_o),
  .timer_clr_o(timer_clr_o), .timer_hold_o(timer_hold_o),
  .st(status_q), .en(en_eff)
);

// File: tb/tb_wk_detect.sv
module tb_wk_detect;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  dma_req_i = '0;
  logic [3:0]  irq_i = '0;
  logic        ring_n_i = 1'b1;
  logic        ac_present_i = 1'b0;
  logic [2:0]  inta_i = '0;
  logic [2:0]  eoi_i = '0;
  logic        refresh_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        smi_event_i = 1'b0;
  logic        pll_start_i = 1'b0;
  logic        pll_ready_i = 1'b0;
  logic        wake_o, activity_o, timer_clr_o, timer_hold_o;

  int checks = 0;
  int errors = 0;

  wk_detect dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  function automatic int pulse_kind(input logic [2:0] m);
    if (m == 3'd3 || m == 3'd4 || m == 3'd5) return 1;
    if (m == 3'd1 || m == 3'd2) return 2;
    return 0;
  endfunction

  task automatic set_line(input int src, input logic v);
    if (src < 6) dma_req_i[src] = v;
    else         irq_i[src-6] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed));
    step(2);
    rst_n = 1'b1;
    step(1);

    rd(3'd0, d); check("R11 mask reset", d, 0);
    rd(3'd1, d); check("R11 status reset", d, 0);
    rd(3'd2, d); check("R11 ctrl reset", d, 0);
    check("R11 outputs reset", {wake_o, activity_o, timer_clr_o, timer_hold_o}, 0);

    wr(3'd0, 16'h0FFF);
    rd(3'd0, d); check("R5 mask readback", d, 16'h0FFF);

    // Directed R1/R6/R8: DMA channel bit 0 in sleep mode
    mode_i = 3'd3;
    dma_req_i[0] = 1'b1;
    step(2);
    rd(3'd1, d); check("R1 not yet visible", d[0], 0);
    step(1);
    rd(3'd1, d); check("R1 status set", d[0], 1);
    check("R6 wake pulse", wake_o, 1);
    check("R6 no activity in sleep", activity_o, 0);
    step(1);
    check("R6 wake single cycle", wake_o, 0);
    check("R8 timer clear after rise", timer_clr_o, 1);
    step(1);
    check("R8 timer clear single cycle", timer_clr_o, 0);
    dma_req_i[0] = 1'b0;
    step(3);
    rd(3'd1, d); check("R1 status released", d[0], 0);

    // Random mix over level-released sources, modes and masks
    for (int it = 0; it < 60; it++) begin
      int src;
      logic [2:0] m;
      logic [15:0] mk;
      int k;
      src = $urandom_range(0, 9);
      m   = 3'($urandom_range(0, 7));
      mk  = 16'($urandom & 32'h0FFF);
      wr(3'd0, mk);
      mode_i = m;
      set_line(src, 1'b1);
      step(3);
      rd(3'd1, d);
      check((src < 6) ? "R1 random set" : "R2 random set", d, 32'h1 << src);
      k = mk[src] ? pulse_kind(m) : 0;
      check(mk[src] ? "R6 random wake" : "R7 masked wake", wake_o, (k == 1));
      check(mk[src] ? "R6 random activity" : "R7 masked activity", activity_o, (k == 2));
      step(1);
      check("R6 random pulse ends", {wake_o, activity_o}, 0);
      set_line(src, 1'b0);
      step(3);
      rd(3'd1, d);
      check((src < 6) ? "R1 random release" : "R2 random release", d, 0);
    end

    // R2: acknowledge-then-EOI release on irq_i[1] (status bit 7)
    wr(3'd0, 16'h0FFF);
    mode_i = 3'd1;
    irq_i[1] = 1'b1;
    step(3);
    check("R2 activity on irq", activity_o, 1);
    eoi_i[0] = 1'b1; step(1); eoi_i[0] = 1'b0;
    rd(3'd1, d); check("R2 eoi alone ignored", d[7], 1);
    inta_i[0] = 1'b1; step(1); inta_i[0] = 1'b0;
    rd(3'd1, d); check("R2 ack alone keeps status", d[7], 1);
    eoi_i[0] = 1'b1; step(1); eoi_i[0] = 1'b0;
    rd(3'd1, d); check("R2 ack then eoi clears", d[7], 0);
    step(2);
    rd(3'd1, d); check("R2 stays clear while line high", d[7], 0);
    irq_i[1] = 1'b0;
    step(3);

    // R3: ring-indicate
    mode_i = 3'd4;
    ring_n_i = 1'b0;
    step(3);
    rd(3'd1, d); check("R3 ring set on fall", d[10], 1);
    check("R6 wake in suspend", wake_o, 1);
    wr(3'd1, 16'h0400);
    rd(3'd1, d); check("R3 software clear ignored", d[10], 1);
    ring_n_i = 1'b1;
    step(3);
    rd(3'd1, d); check("R3 line high ignored", d[10], 1);
    refresh_i = 1'b1; step(1); refresh_i = 1'b0;
    rd(3'd1, d); check("R3 refresh clears", d[10], 0);

    // R4: AC-present double enable, R5 software clear
    mode_i = 3'd3;
    wr(3'd0, 16'h0800);
    ac_present_i = 1'b1;
    step(3);
    rd(3'd1, d); check("R4 ac status recorded", d[11], 1);
    check("R4 no wake without ctrl enable", wake_o, 0);
    step(2);
    check("R4 still no wake", wake_o, 0);
    wr(3'd2, 16'h0001);
    check("R4 wake once both enables set", wake_o, 1);
    wr(3'd1, 16'h0800);
    rd(3'd1, d); check("R5 w1c clears ac bit", d[11], 0);
    ac_present_i = 1'b0;
    wr(3'd2, 16'h0000);
    step(2);

    // R5: w1c on a DMA bit, zero bits untouched
    wr(3'd0, 16'h0000);
    dma_req_i[2] = 1'b1; dma_req_i[4] = 1'b1;
    step(3);
    wr(3'd1, 16'h0004);
    rd(3'd1, d); check("R5 w1c clears only written bit", d, 16'h0010);
    dma_req_i = '0;
    step(3);

    // R8: mode-command write
    wr(3'd3, 16'h0000);
    check("R8 clear on mode-command write", timer_clr_o, 1);
    step(1);
    check("R8 clear ends", timer_clr_o, 0);

    // R9: SMI hold
    smi_event_i = 1'b1; step(1); smi_event_i = 1'b0;
    check("R9 hold set", timer_hold_o, 1);
    step(5);
    check("R9 hold kept", timer_hold_o, 1);
    wr(3'd4, 16'h0000);
    check("R9 hold released", timer_hold_o, 0);

    // R10: PLL hold
    pll_start_i = 1'b1; step(1); pll_start_i = 1'b0;
    check("R10 hold set", timer_hold_o, 1);
    step(4);
    check("R10 hold kept", timer_hold_o, 1);
    pll_ready_i = 1'b1; step(1); pll_ready_i = 1'b0;
    check("R10 hold released", timer_hold_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule